// File: doc/BRIEF.md
# Interlaced Video Sync Master

This block is the timing source for an interlaced video encoder that always acts as sync master. It runs from a double-rate pixel clock and drives the divided pixel clock, active-low horizontal and vertical sync strobes, a field flag, a blanking flag, and the position within the frame. The upstream decoder uses these to pace its pixel data. The block has no sync or pixel-clock inputs.

A 2-bit mode input selects one of four modes: 525-line timing, 625-line timing, a 625-style colour mode that keeps 525-line timing, or sleep. In sleep the encoder timing stops but the pixel clock keeps running. A new mode is taken up only at the end of the current frame, so the frame that is in progress always completes. The second field of each frame starts its vertical sync half a line later than the first field, which gives the interlace offset.

Top module: `vsync_master_gen`

## Requirements
- R1: `mode_sel` is decoded as follows. 2'b11 gives LINE_CLKS_525 clocks per line and FRAME_LINES_525 lines per frame. 2'b01 uses the same 525-line timing. 2'b10 gives LINE_CLKS_625 clocks per line and FRAME_LINES_625 lines per frame. 2'b00 selects sleep.
- R2: While active, `h_count` counts double-rate clocks from 0 to line length − 1. `v_count` counts lines from 0 to frame lines − 1 and advances on each line wrap.
- R3: `hsync_n` is low for exactly the first HSYNC_CLKS clocks of every line, from `h_count` 0 to HSYNC_CLKS − 1.
- R4: The first field's vertical sync starts at line 0, `h_count` 0. `vsync_n` stays low for VSYNC_LINES whole lines, counted in clocks.
- R5: The second field's vertical sync starts at line (frame lines − 1)/2, at `h_count` = line length/2, and lasts the same VSYNC_LINES lines.
- R6: `field2` is 0 in the first field. It is 1 from the start of the second field's vertical sync until the frame ends. It therefore changes at every vertical sync start.
- R7: `pclk_out` is 0 in reset and toggles on every double-rate clock in every mode, sleep included.
- R8: A change on `mode_sel` takes effect after the last clock of the last line of the frame. When the block is in sleep, the change takes effect on the next clock.
- R9: In sleep, `hsync_n` and `vsync_n` are high, both counters are 0, `blank` is 1 and `sleeping` is 1.
- R10: `blank` is 1 when `h_count` < HBLANK_CLKS, or when the position lies within the first VBLANK_LINES lines (counted in half lines) of either field.
- R11: While reset is held, the block is in sleep with all outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Requested video mode |
| pclk_out | output | 1 | Pixel clock, clk2x divided by 2 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field2 | output | 1 | High during the second field |
| h_count | output | H_W | Clock position within the line |
| v_count | output | V_W | Line position within the frame |
| blank | output | 1 | Blanking interval flag |
| sleeping | output | 1 | Encoder timing stopped |

## Verification
The hardest case to reach is a mode request that arrives mid-frame and has to wait for the frame boundary. This matters most when the request is sleep: the only sign of the deferral is that the old line length and sync pattern carry on unchanged. The bench changes `mode_sel` a few clocks into a frame. It then counts to the final clock of that frame and checks that the old timing holds up to that clock and that the new mode appears on the clock after it. The bench uses a shortened line and frame geometry, so that whole frames, both field syncs and these boundaries occur many times within a short run.

// File: rtl/vsync_master_pkg.sv
package vsync_master_pkg;

    typedef enum logic [1:0] {
        VM_SLEEP = 2'b00,
        VM_ALT60 = 2'b01,
        VM_L625  = 2'b10,
        VM_L525  = 2'b11
    } vid_mode_e;

    typedef struct packed {
        vid_mode_e mode;
        logic      pclk;
    } ctl_state_t;

endpackage

// File: rtl/vsm_line_counter.sv
module vsm_line_counter #(
    parameter int H_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [H_W-1:0] line_len,
    output logic [H_W-1:0] h_count,
    output logic           line_last
);

    typedef struct packed {
        logic [H_W-1:0] h;
    } line_state_t;

    line_state_t line_q, line_d;

    always_comb begin
        line_last = run && (line_q.h == line_len - 1'b1);
        line_d    = line_q;
        if (!run || line_last) begin
            line_d.h = '0;
        end else begin
            line_d.h = line_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign h_count = line_q.h;

    // R2: inside a line the position advances by one per clock
    a_r2_h_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_last) |=> (h_count == $past(h_count) + 1'b1));

endmodule

// File: rtl/vsm_frame_counter.sv
module vsm_frame_counter #(
    parameter int V_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           line_last,
    input  logic [V_W-1:0] frame_lines,
    output logic [V_W-1:0] v_count,
    output logic           frame_last
);

    typedef struct packed {
        logic [V_W-1:0] v;
    } frame_state_t;

    frame_state_t frm_q, frm_d;

    always_comb begin
        frame_last = line_last && (frm_q.v == frame_lines - 1'b1);
        frm_d      = frm_q;
        if (!run || frame_last) begin
            frm_d.v = '0;
        end else if (line_last) begin
            frm_d.v = frm_q.v + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign v_count = frm_q.v;

    // R2: the line number only moves on a line wrap
    a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_last) |=> $stable(v_count));

endmodule

// File: rtl/vsync_master_gen.sv
module vsync_master_gen
    import vsync_master_pkg::*;
#(
    parameter int LINE_CLKS_525   = 1716,
    parameter int LINE_CLKS_625   = 1728,
    parameter int FRAME_LINES_525 = 525,
    parameter int FRAME_LINES_625 = 625,
    parameter int HSYNC_CLKS      = 64,
    parameter int VSYNC_LINES     = 3,
    parameter int HBLANK_CLKS     = 276,
    parameter int VBLANK_LINES    = 20,
    localparam int H_W = $clog2((LINE_CLKS_625 > LINE_CLKS_525) ? LINE_CLKS_625 : LINE_CLKS_525),
    localparam int V_W = $clog2((FRAME_LINES_625 > FRAME_LINES_525) ? FRAME_LINES_625 : FRAME_LINES_525)
) (
    input  logic           clk2x,
    input  logic           rst_n,
    input  logic [1:0]     mode_sel,
    output logic           pclk_out,
    output logic           hsync_n,
    output logic           vsync_n,
    output logic           field2,
    output logic [H_W-1:0] h_count,
    output logic [V_W-1:0] v_count,
    output logic           blank,
    output logic           sleeping
);

    localparam int HL_W = V_W + 1;

    ctl_state_t     cur_q, cur_d;
    logic           run;
    logic           is625;
    logic [H_W-1:0] line_len;
    logic [V_W-1:0] frame_lines;
    logic           line_last;
    logic           frame_last;
    logic           second_half;
    logic [HL_W-1:0] half_idx;
    logic [HL_W-1:0] f2_start;
    logic           in_f2;
    logic [HL_W-1:0] rel_half;

    vsm_line_counter #(.H_W(H_W)) u_line (
        .clk       (clk2x),
        .rst_n     (rst_n),
        .run       (run),
        .line_len  (line_len),
        .h_count   (h_count),
        .line_last (line_last)
    );

    vsm_frame_counter #(.V_W(V_W)) u_frame (
        .clk         (clk2x),
        .rst_n       (rst_n),
        .run         (run),
        .line_last   (line_last),
        .frame_lines (frame_lines),
        .v_count     (v_count),
        .frame_last  (frame_last)
    );

    always_comb begin
        run         = (cur_q.mode != VM_SLEEP);
        is625       = (cur_q.mode == VM_L625);
        line_len    = is625 ? H_W'(LINE_CLKS_625)   : H_W'(LINE_CLKS_525);
        frame_lines = is625 ? V_W'(FRAME_LINES_625) : V_W'(FRAME_LINES_525);

        // position in half lines; the second field begins at half line N
        second_half = (h_count >= (line_len >> 1));
        half_idx    = {v_count, second_half};
        f2_start    = {1'b0, frame_lines};
        in_f2       = (half_idx >= f2_start);
        rel_half    = in_f2 ? (half_idx - f2_start) : half_idx;

        cur_d      = cur_q;
        cur_d.pclk = ~cur_q.pclk;
        if (!run || frame_last) begin
            cur_d.mode = vid_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= VM_SLEEP;
            cur_q.pclk <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign pclk_out = cur_q.pclk;
    assign sleeping = !run;
    assign hsync_n  = !(run && (h_count < H_W'(HSYNC_CLKS)));
    assign vsync_n  = !(run && (rel_half < HL_W'(2 * VSYNC_LINES)));
    assign field2   = in_f2;
    assign blank    = !run || (h_count < H_W'(HBLANK_CLKS))
                    || (rel_half < HL_W'(2 * VBLANK_LINES));

    // R9: sleep keeps the sync strobes and counters idle
    a_r9_sleep_idle: assert property (@(posedge clk2x) disable iff (!rst_n)
        sleeping |-> (hsync_n && vsync_n && blank && h_count == '0 && v_count == '0));

    // R8: the active mode holds until the frame ends
    a_r8_mode_hold: assert property (@(posedge clk2x) disable iff (!rst_n)
        (run && !frame_last) |=> (cur_q.mode == $past(cur_q.mode)));

    // R7: pixel clock flips on every double-rate edge
    a_r7_pclk_toggle: assert property (@(posedge clk2x) disable iff (!rst_n)
        1'b1 |=> (pclk_out != $past(pclk_out)));

    // R6: each vertical sync start enters the other field
    a_r6_field_flip: assert property (@(posedge clk2x) disable iff (!rst_n)
        ($fell(vsync_n) && !$past(sleeping)) |-> (field2 != $past(field2)));

    // R3: horizontal sync opens at the line start
    a_r3_hsync_start: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(hsync_n) |-> (h_count == '0));

endmodule

// File: tb/tb_vsync_master_gen.sv
`timescale 1ns/1ps
module tb_vsync_master_gen;

    localparam int BL525 = 40;
    localparam int BL625 = 48;
    localparam int BN525 = 11;
    localparam int BN625 = 13;
    localparam int BHS   = 8;
    localparam int BVS   = 3;
    localparam int BHB   = 12;
    localparam int BVB   = 4;
    localparam int HW    = $clog2(BL625);
    localparam int VW    = $clog2(BN625);

    logic          clk2x = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic          pclk_out, hsync_n, vsync_n, field2, blank, sleeping;
    logic [HW-1:0] h_count;
    logic [VW-1:0] v_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model state
    int m_mode = 0;
    int m_h = 0;
    int m_v = 0;
    int m_pclk = 0;

    // measurement state
    int hs_run = 0;
    int vs_run = 0;
    int prev_hs = 1;
    int prev_vs = 1;
    int prev_field = 0;
    int prev_sleep = 1;

    always #2 clk2x = ~clk2x;

    vsync_master_gen #(
        .LINE_CLKS_525(BL525), .LINE_CLKS_625(BL625),
        .FRAME_LINES_525(BN525), .FRAME_LINES_625(BN625),
        .HSYNC_CLKS(BHS), .VSYNC_LINES(BVS),
        .HBLANK_CLKS(BHB), .VBLANK_LINES(BVB)
    ) dut (
        .clk2x(clk2x), .rst_n(rst_n), .mode_sel(mode_sel),
        .pclk_out(pclk_out), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .field2(field2), .h_count(h_count), .v_count(v_count),
        .blank(blank), .sleeping(sleeping)
    );

    function automatic int mlen(int m);
        return (m == 2) ? BL625 : BL525;
    endfunction

    function automatic int mlines(int m);
        return (m == 2) ? BN625 : BN525;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_adv();
        int L = mlen(m_mode);
        int N = mlines(m_mode);
        if (m_mode == 0) begin
            m_mode = int'(mode_sel);
            m_h = 0;
            m_v = 0;
        end else if (m_h == L - 1) begin
            m_h = 0;
            if (m_v == N - 1) begin
                m_v = 0;
                m_mode = int'(mode_sel);
            end else begin
                m_v++;
            end
        end else begin
            m_h++;
        end
        m_pclk = 1 - m_pclk;
    endtask

    task automatic compare_all();
        int L = mlen(m_mode);
        int N = mlines(m_mode);
        int run = (m_mode != 0) ? 1 : 0;
        int hl = 2 * m_v + ((m_h >= L / 2) ? 1 : 0);
        int rel = (hl >= N) ? hl - N : hl;
        chk("R7 pclk_out", int'(pclk_out), m_pclk);
        chk("R2 h_count", int'(h_count), m_h);
        chk("R2 v_count", int'(v_count), m_v);
        chk("R3 hsync_n", int'(hsync_n), (run != 0 && m_h < BHS) ? 0 : 1);
        chk("R4 vsync_n", int'(vsync_n), (run != 0 && rel < 2 * BVS) ? 0 : 1);
        chk("R6 field2", int'(field2), (run != 0 && hl >= N) ? 1 : 0);
        chk("R10 blank", int'(blank), (run == 0 || m_h < BHB || rel < 2 * BVB) ? 1 : 0);
        chk("R9 sleeping", int'(sleeping), (run == 0) ? 1 : 0);

        // pulse measurements at the ports
        if (!hsync_n) begin
            hs_run++;
        end else if (prev_hs == 0) begin
            chk("R3 hsync low width", hs_run, BHS);
            hs_run = 0;
        end
        if (prev_vs == 1 && !vsync_n) begin
            chk("R5 vsync start position", int'(h_count), field2 ? L / 2 : 0);
            if (prev_sleep == 0) chk("R6 field flips at vsync", int'(field2), 1 - prev_field);
        end
        if (!vsync_n) begin
            vs_run++;
        end else if (prev_vs == 0) begin
            chk("R4 vsync low width", vs_run, BVS * L);
            vs_run = 0;
        end
        prev_hs = int'(hsync_n);
        prev_vs = int'(vsync_n);
        prev_field = int'(field2);
        prev_sleep = int'(sleeping);
    endtask

    task automatic step();
        @(posedge clk2x);
        model_adv();
        @(negedge clk2x);
        compare_all();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mode_sel = 2'b11;
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        chk("R11 reset sleeping", int'(sleeping), 1);
        chk("R11 reset hsync_n", int'(hsync_n), 1);
        chk("R11 reset vsync_n", int'(vsync_n), 1);
        chk("R11 reset blank", int'(blank), 1);
        chk("R11 reset counters", int'(h_count) + int'(v_count), 0);
        chk("R7 reset pclk_out", int'(pclk_out), 0);
        mode_sel = 2'b00;
        rst_n = 1'b1;
    endtask

    // switch to a mode and run whole frames of it; checks counter ranges (R1)
    task automatic t_mode_run(logic [1:0] sel, int frames);
        int max_h = 0;
        int max_v = 0;
        mode_sel = sel;
        for (int i = 0; i < 3000 && m_mode != int'(sel); i++) step();
        for (int i = 0; i < frames * mlen(int'(sel)) * mlines(int'(sel)); i++) begin
            step();
            if (int'(h_count) > max_h) max_h = int'(h_count);
            if (int'(v_count) > max_v) max_v = int'(v_count);
        end
        chk("R1 last clock of line", max_h, mlen(int'(sel)) - 1);
        chk("R1 last line of frame", max_v, mlines(int'(sel)) - 1);
        chk("R1 ends at frame start", int'(h_count) + int'(v_count), 0);
    endtask

    // mid-frame request for 625-line timing while in 525-line timing
    task automatic t_defer();
        for (int i = 0; i < 5; i++) step();
        mode_sel = 2'b10;
        for (int i = 0; i < BL525 * BN525 - 1 - 5; i++) step();
        chk("R8 old line length kept to end", int'(h_count), BL525 - 1);
        chk("R8 old frame kept to end", int'(v_count), BN525 - 1);
        step();
        chk("R8 new frame starts", int'(h_count) + int'(v_count), 0);
        for (int i = 0; i < BL525; i++) step();
        chk("R1 625 line longer", int'(h_count), BL525);
        for (int i = 0; i < BL625 * BN625 - BL525; i++) step();
    endtask

    // mid-frame sleep request, idle period, wake-up
    task automatic t_sleep();
        for (int i = 0; i < 20; i++) step();
        mode_sel = 2'b00;
        for (int i = 0; i < BL525 * BN525 - 21; i++) step();
        chk("R8 sleep deferred", int'(sleeping), 0);
        step();
        chk("R8 sleep at frame boundary", int'(sleeping), 1);
        for (int i = 0; i < 30; i++) begin
            step();
            chk("R9 sleep sync idle", int'(hsync_n) + int'(vsync_n), 2);
        end
        mode_sel = 2'b11;
        step();
        chk("R8 wake next clock", int'(sleeping), 0);
        chk("R4 wake vsync low", int'(vsync_n), 0);
        chk("R3 wake hsync low", int'(hsync_n), 0);
        for (int i = 0; i < BL525 * BN525; i++) step();
    endtask

    initial begin
        t_reset();
        t_mode_run(2'b11, 2);
        t_defer();
        t_mode_run(2'b10, 1);
        t_mode_run(2'b01, 2);
        t_sleep();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk2x);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete (R2 timing stalled)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule